// File: doc/BRIEF.md
# DMA Beat Address Generator

This block produces the source memory address of every beat in one DMA block transfer. The channel descriptor holds the address where the block ends, not where it starts. When a block is accepted, the generator captures the stored address, the beat count, the beat size, the increment enable, the step-select bit and the step size. It then works backwards from the stored address to the address of the first beat, and issues that address. Each time a beat is accepted it moves to the next address, until no beats remain.

A second, independent path forms the byte address of a channel's source-address descriptor field from a base pointer and a channel number. A controller uses this path to fetch descriptors.

A block is handed over with a valid/ready handshake, and each beat address is consumed through a second valid/ready pair. When the last beat is taken, a single-cycle completion pulse is raised.

Top module: `dma_beat_addr_gen`

## Requirements
- R1: While and after synchronous reset, with no start accepted, `beat_valid`=0, `done`=0, `start_ready`=1, `beats_left`=0 and `beat_addr`=0.
- R2: One clock after `base_ptr` and `chan_id` are presented, `src_field_addr` equals base_ptr + chan_id*16 + 4, modulo 2^32.
- R3: When `inc_en`=0, every beat of the block carries exactly `stored_addr`.
- R4: When `inc_en`=1 and `step_sel`=0, the first beat address is stored_addr − beat_cnt*(beat_size+1). Each following beat is (beat_size+1) higher than the one before.
- R5: When `inc_en`=1 and `step_sel`=1, the first beat address is stored_addr − beat_cnt*(beat_size+1)*2^step_size, where `step_size` is 3 bits (multiplier 1..128). Each following beat is (beat_size+1)*2^step_size higher.
- R6: The beat address and `beats_left` advance only in a cycle where `beat_valid` and `beat_ready` are both 1. While `beat_ready`=0 they hold.
- R7: In the cycle after a start is accepted, `beats_left` equals `beat_cnt` and `beat_valid`=1. `beats_left` then drops by one per accepted beat.
- R8: In the cycle after the last beat is accepted, `done` is 1 for exactly one cycle, `beat_valid` is 0 and `start_ready` is 1.
- R9: A start with `beat_cnt`=0 raises `done` in the next cycle and issues no beat (`beat_valid` stays 0).
- R10: All address arithmetic wraps modulo 2^32.
- R11: While a block is in progress, `start_ready`=0 and `start_valid` together with the block fields have no effect on the addresses issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_ptr | input | 32 | Descriptor table base address |
| chan_id | input | 5 | Channel number |
| src_field_addr | output | 32 | Registered address of the channel's source-address descriptor field |
| start_valid | input | 1 | Block fields are valid |
| start_ready | output | 1 | Generator idle and able to accept a block |
| stored_addr | input | 32 | End-of-block source address from the descriptor |
| beat_cnt | input | 16 | Number of beats in the block |
| beat_size | input | 2 | Bytes per beat minus one |
| inc_en | input | 1 | Source address incrementing enabled |
| step_sel | input | 1 | Apply the step-size multiplier |
| step_size | input | 3 | Log2 of the beats per increment |
| beat_valid | output | 1 | `beat_addr` holds a beat to be issued |
| beat_ready | input | 1 | Consumer takes the current beat |
| beat_addr | output | 32 | Current beat source address |
| beats_left | output | 16 | Beats not yet accepted |
| done | output | 1 | One-cycle pulse at block completion |

## Verification
A wrong captured stride or a wrong start span shows on `beat_addr` in the first cycle after the start handshake. The whole address sequence of the block is offset or skewed from then on. A counter fault shows on `beats_left` at the first accepted beat. If the counter is off, `done` also arrives one or more cycles early or late. That misplaces the completion pulse and leaves `beat_valid` asserted in the wrong cycle. A handshake fault, such as advancing during a stall or accepting a start while busy, changes `beat_addr` within one cycle of the offending edge.

// File: rtl/dma_bag_pkg.sv
package dma_bag_pkg;
  typedef enum logic {
    BAG_IDLE = 1'b0,
    BAG_RUN  = 1'b1
  } bag_state_t;
endpackage

// File: rtl/dma_bag_desc_addr.sv
module dma_bag_desc_addr #(
  parameter int ADDR_W   = 32,
  parameter int CH_W     = 5,
  parameter int SLOT_LG  = 4,
  parameter int FIELD_OF = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base_ptr,
  input  logic [CH_W-1:0]   chan_id,
  output logic [ADDR_W-1:0] field_addr
);
  localparam int PAD_W = ADDR_W - CH_W;

  logic [ADDR_W-1:0] slot_off;

  always_comb begin
    slot_off = {{PAD_W{1'b0}}, chan_id} << SLOT_LG;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      field_addr <= '0;
    end else begin
      field_addr <= base_ptr + slot_off + ADDR_W'(FIELD_OF);
    end
  end
endmodule

// File: rtl/dma_bag_span.sv
module dma_bag_span #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int SIZE_W = 2,
  parameter int STEP_W = 3
) (
  input  logic [CNT_W-1:0]  cnt,
  input  logic [SIZE_W-1:0] size,
  input  logic              sel,
  input  logic [STEP_W-1:0] step,
  output logic [ADDR_W-1:0] stride,
  output logic [ADDR_W-1:0] span
);
  localparam int SZ_PAD  = ADDR_W - SIZE_W;
  localparam int CNT_PAD = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] unit;

  always_comb begin
    unit   = {{SZ_PAD{1'b0}}, size} + ADDR_W'(1);
    stride = sel ? (unit << step) : unit;
    span   = {{CNT_PAD{1'b0}}, cnt} * stride;
  end
endmodule

// File: rtl/dma_bag_beat_cnt.sv
module dma_bag_beat_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             is_last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (dec && count != '0) begin
      count <= count - CNT_W'(1);
    end
  end

  always_comb begin
    is_last = (count == CNT_W'(1));
  end

  // R7: an accepted decrement lowers the count by exactly one
  a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && count > CNT_W'(1)) |=> (count == $past(count) - CNT_W'(1)));
endmodule

// File: rtl/dma_beat_addr_gen.sv
module dma_beat_addr_gen
  import dma_bag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int SIZE_W   = 2,
  parameter int STEP_W   = 3,
  parameter int CH_W     = 5,
  parameter int SLOT_LG  = 4,
  parameter int FIELD_OF = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base_ptr,
  input  logic [CH_W-1:0]   chan_id,
  output logic [ADDR_W-1:0] src_field_addr,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [ADDR_W-1:0] stored_addr,
  input  logic [CNT_W-1:0]  beat_cnt,
  input  logic [SIZE_W-1:0] beat_size,
  input  logic              inc_en,
  input  logic              step_sel,
  input  logic [STEP_W-1:0] step_size,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [CNT_W-1:0]  beats_left,
  output logic              done
);
  bag_state_t        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] stride_q;
  logic              done_q;
  logic [ADDR_W-1:0] new_stride;
  logic [ADDR_W-1:0] new_span;
  logic              start_fire;
  logic              beat_fire;
  logic              cnt_last;

  dma_bag_desc_addr #(
    .ADDR_W(ADDR_W), .CH_W(CH_W), .SLOT_LG(SLOT_LG), .FIELD_OF(FIELD_OF)
  ) i_desc (
    .clk(clk), .rst(rst), .base_ptr(base_ptr), .chan_id(chan_id),
    .field_addr(src_field_addr)
  );

  dma_bag_span #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SIZE_W(SIZE_W), .STEP_W(STEP_W)
  ) i_span (
    .cnt(beat_cnt), .size(beat_size), .sel(step_sel), .step(step_size),
    .stride(new_stride), .span(new_span)
  );

  dma_bag_beat_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst(rst), .load(start_fire), .load_val(beat_cnt),
    .dec(beat_fire), .count(beats_left), .is_last(cnt_last)
  );

  always_comb begin
    start_ready = (state_q == BAG_IDLE);
    beat_valid  = (state_q == BAG_RUN);
    start_fire  = start_valid && start_ready;
    beat_fire   = beat_valid && beat_ready;
    beat_addr   = addr_q;
    done        = done_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= BAG_IDLE;
      addr_q   <= '0;
      stride_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        BAG_IDLE: begin
          if (start_fire) begin
            if (beat_cnt == '0) begin
              done_q <= 1'b1;
            end else begin
              state_q  <= BAG_RUN;
              addr_q   <= inc_en ? (stored_addr - new_span) : stored_addr;
              stride_q <= inc_en ? new_stride : '0;
            end
          end
        end
        BAG_RUN: begin
          if (beat_fire) begin
            addr_q <= addr_q + stride_q;
            if (cnt_last) begin
              state_q <= BAG_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        default: state_q <= BAG_IDLE;
      endcase
    end
  end

  // R8: completion pulse lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: last accepted beat ends the block
  a_r8_last_beat: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ready && beats_left == CNT_W'(1)) |=> (done && !beat_valid));

  // R6: a stalled beat holds address and count
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_ready) |=> ($stable(beat_addr) && $stable(beats_left)));

  // R11: no start accepted while a block runs
  a_r11_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> !start_ready);

  // R9: an empty block completes without issuing a beat
  a_r9_empty_block: assert property (@(posedge clk) disable iff (rst)
    (start_valid && start_ready && beat_cnt == '0) |=> (done && !beat_valid));
endmodule

// File: tb/test_dma_beat_addr_gen.sv
module test_dma_beat_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] base_ptr = '0;
  logic [4:0]  chan_id = '0;
  logic [31:0] src_field_addr;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [31:0] stored_addr = '0;
  logic [15:0] beat_cnt = '0;
  logic [1:0]  beat_size = '0;
  logic        inc_en = 1'b0;
  logic        step_sel = 1'b0;
  logic [2:0]  step_size = '0;
  logic        beat_valid;
  logic        beat_ready = 1'b0;
  logic [31:0] beat_addr;
  logic [15:0] beats_left;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma_beat_addr_gen i_dma_beat_addr_gen (
    .clk(clk), .rst(rst), .base_ptr(base_ptr), .chan_id(chan_id),
    .src_field_addr(src_field_addr), .start_valid(start_valid),
    .start_ready(start_ready), .stored_addr(stored_addr), .beat_cnt(beat_cnt),
    .beat_size(beat_size), .inc_en(inc_en), .step_sel(step_sel),
    .step_size(step_size), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_addr(beat_addr), .beats_left(beats_left), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(beat_valid == 1'b0, "R1 beat_valid", 32'(beat_valid), 0);
    chk(done == 1'b0, "R1 done", 32'(done), 0);
    chk(start_ready == 1'b1, "R1 start_ready", 32'(start_ready), 1);
    chk(beats_left == 16'd0, "R1 beats_left", 32'(beats_left), 0);
    chk(beat_addr == 32'd0, "R1 beat_addr", beat_addr, 0);
  endtask

  task automatic t_fetch(input logic [31:0] b, input logic [4:0] c);
    logic [31:0] e;
    base_ptr = b;
    chan_id  = c;
    @(negedge clk);
    e = b + {27'd0, c} * 32'd16 + 32'd4;
    chk(src_field_addr == e, "R2 field address", src_field_addr, e);
  endtask

  task automatic run_block(input logic [31:0] sa, input logic [15:0] n,
                           input logic [1:0] sz, input bit inc, input bit sel,
                           input logic [2:0] st, input string req,
                           input int stall_at, input bit poke);
    logic [31:0] stride;
    logic [31:0] exp;
    logic [31:0] hold_a;
    stride = {30'd0, sz} + 32'd1;
    if (sel) stride = stride << st;
    if (!inc) stride = 32'd0;
    exp = sa - {16'd0, n} * stride;
    start_valid = 1'b1;
    stored_addr = sa;
    beat_cnt    = n;
    beat_size   = sz;
    inc_en      = inc;
    step_sel    = sel;
    step_size   = st;
    @(negedge clk);
    start_valid = 1'b0;
    chk(beat_valid == 1'b1, "R7 valid after start", 32'(beat_valid), 1);
    for (int i = 0; i < int'(n); i++) begin
      chk(beat_addr == exp, req, beat_addr, exp);
      chk(beats_left == n - 16'(i), "R7 beats_left", 32'(beats_left), 32'(n - 16'(i)));
      if (i == stall_at) begin
        hold_a = beat_addr;
        beat_ready = 1'b0;
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk(beat_addr == hold_a, "R6 stall addr", beat_addr, hold_a);
          chk(beats_left == n - 16'(i), "R6 stall count", 32'(beats_left), 32'(n - 16'(i)));
        end
      end
      if (poke && i == 1) begin
        chk(start_ready == 1'b0, "R11 busy ready", 32'(start_ready), 0);
        start_valid = 1'b1;
        stored_addr = 32'h5555_0000;
        beat_cnt    = 16'd9;
        inc_en      = 1'b1;
        step_sel    = 1'b1;
        step_size   = 3'd7;
      end
      beat_ready = 1'b1;
      @(negedge clk);
      start_valid = 1'b0;
      exp = exp + stride;
    end
    beat_ready = 1'b0;
    chk(done == 1'b1, "R8 done pulse", 32'(done), 1);
    chk(beat_valid == 1'b0, "R8 valid drops", 32'(beat_valid), 0);
    chk(start_ready == 1'b1, "R8 ready again", 32'(start_ready), 1);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", 32'(done), 0);
    chk(beat_valid == 1'b0, "R11 no late start", 32'(beat_valid), 0);
  endtask

  task automatic t_empty();
    start_valid = 1'b1;
    beat_cnt    = 16'd0;
    stored_addr = 32'h1234_5678;
    inc_en      = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    chk(done == 1'b1, "R9 empty done", 32'(done), 1);
    chk(beat_valid == 1'b0, "R9 no beat", 32'(beat_valid), 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done drops", 32'(done), 0);
    chk(beat_valid == 1'b0, "R9 still no beat", 32'(beat_valid), 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fetch(32'h2000_0000, 5'd0);
    t_fetch(32'h2000_0100, 5'd3);
    t_fetch(32'hFFFF_FFF0, 5'd31);
    run_block(32'h0000_4000, 16'd5, 2'd2, 1'b0, 1'b0, 3'd0, "R3 fixed addr", -1, 1'b0);
    run_block(32'h0000_1000, 16'd6, 2'd3, 1'b1, 1'b0, 3'd5, "R4 unit step", -1, 1'b0);
    run_block(32'h0000_1000, 16'd4, 2'd1, 1'b1, 1'b1, 3'd3, "R5 scaled step", -1, 1'b0);
    run_block(32'h0008_0000, 16'd3, 2'd0, 1'b1, 1'b1, 3'd7, "R5 max step", -1, 1'b0);
    run_block(32'h0000_2000, 16'd5, 2'd3, 1'b1, 1'b0, 3'd0, "R6 stall seq", 2, 1'b0);
    run_block(32'h0000_0010, 16'd8, 2'd3, 1'b1, 1'b1, 3'd2, "R10 wrap", -1, 1'b0);
    run_block(32'h0000_3000, 16'd4, 2'd1, 1'b1, 1'b0, 3'd0, "R11 busy ignore", -1, 1'b1);
    run_block(32'h0000_0100, 16'd1, 2'd0, 1'b1, 1'b0, 3'd0, "R4 single beat", -1, 1'b0);
    t_empty();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule